// File: doc/BRIEF.md
# Double-Precision Floating Compare Unit

This unit takes two IEEE-754 double-precision operands and finds their ordering. The result is a one-hot 4-bit condition code meaning less, greater, equal or unordered. Each compare also updates a 32-bit status register. That register holds a copy of the condition code and a few sticky invalid-operation flags.

A single-cycle start strobe launches a compare. A mode input picks one of two compares:

- The unordered compare raises its two NaN flags and never clears them.
- The ordered compare first clears its own NaN flag. It then raises that flag together with a second flag whenever an operand is a NaN.

The registered code and status appear one clock after the strobe, together with a one-cycle done pulse. Between strobes the code and the status hold their values. The block does not deliver traps, and it does not write the code into any wider condition register.

The status register is split into nibbles. Nibble k is bits [4k+3:4k].

Top module: `fcmp_unit`

## Requirements
- R1: If either operand has an all-ones 11-bit exponent and a nonzero 52-bit fraction, that operand is a NaN and the code is 4'b0001.
- R2: For two non-NaN operands, the code is 4'b1000 when A < B, 4'b0100 when A > B and 4'b0010 when they are equal. Ordering follows sign-magnitude rules, so between two negative values the one with the larger magnitude is the smaller value.
- R3: Positive zero and negative zero compare equal (4'b0010) in either order.
- R4: Infinities are ordered like other values. Minus infinity is below every finite value, plus infinity is above every finite value, and equal infinities compare equal. An infinity is not a NaN.
- R5: Every compare copies its code into status bits [15:12] (nibble 3).
- R6: In unordered mode (mode input 0), a NaN operand sets status bit 16 and status bit 24, and both stay set. A non-NaN unordered compare leaves bits 16, 19 and 24 unchanged.
- R7: In ordered mode (mode input 1), bit 16 is cleared at the start of the compare. A NaN operand then sets bits 16 and 19. Bits 19 and 24 are never cleared by an ordered compare.
- R8: The code and status change only on the clock edge that samples start high. On that edge done goes high for exactly one cycle. With start low, the code and status hold their values.
- R9: Reset, active low, clears the code, the whole status register and done. Status bits outside 12 to 16, 19 and 24 stay zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches a compare |
| ordMode | input | 1 | 1 selects the ordered compare, 0 the unordered compare |
| opA | input | 64 | Operand A, IEEE-754 double |
| opB | input | 64 | Operand B, IEEE-754 double |
| ccOut | output | 4 | One-hot condition code (less, greater, equal, unordered from MSB down) |
| status | output | 32 | Status register: condition nibble and sticky flags |
| done | output | 1 | One-cycle pulse in the cycle after start |

## Verification
The assertions assume that ordMode and both operands are valid and stable in the cycle start is high. They make no assumption about the gap between strobes, because the unit takes a new compare on every strobe. The stimulus changes inputs only on the falling edge and always presents them with the strobe. It uses back-to-back strobes, idle gaps, mode changes between NaN and non-NaN compares, and a reset in the middle of the run, so the sticky flags are seen set, held and partly cleared.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int NIB_W    = 4;
  localparam int CC_NIB   = 3;   // condition-code nibble
  localparam int INV_NIB  = 4;   // invalid-compare flags nibble
  localparam int XNAN_NIB = 6;   // unordered NaN flag nibble

  typedef enum logic [3:0] {
    CC_NONE = 4'b0000,
    CC_UN   = 4'b0001,
    CC_EQ   = 4'b0010,
    CC_GT   = 4'b0100,
    CC_LT   = 4'b1000
  } fcmpCode_e;

  typedef struct packed {
    logic load;     // capture code and status this cycle
    logic ordered;  // ordered-compare flag handling
  } fcmpStrobe_t;
endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ordMode,
  output fcmpStrobe_t strobe,
  output logic        done
);
  always_comb begin
    strobe.load    = start;
    strobe.ordered = ordMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= start;
  end

  // R8
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
endmodule

// File: rtl/fcmp_dpath.sv
module fcmp_dpath
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int STAT_NIBBLES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fcmpStrobe_t              strobe,
  input  logic [EXP_W+FRAC_W:0]    opA,
  input  logic [EXP_W+FRAC_W:0]    opB,
  output logic [3:0]               ccOut,
  output logic [STAT_NIBBLES*NIB_W-1:0] status
);
  localparam int OP_W   = 1 + EXP_W + FRAC_W;
  localparam int STAT_W = STAT_NIBBLES * NIB_W;
  localparam int INV_BIT  = INV_NIB * NIB_W;
  localparam int INVX_BIT = INV_NIB * NIB_W + 3;
  localparam int XNAN_BIT = XNAN_NIB * NIB_W;

  logic [OP_W-1:0]   ops     [2];
  logic              opSign  [2];
  logic [OP_W-2:0]   opMag   [2];
  logic              opNan   [2];

  assign ops[0] = opA;
  assign ops[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_class
    assign opSign[i] = ops[i][OP_W-1];
    assign opMag[i]  = ops[i][OP_W-2:0];
    assign opNan[i]  = (&ops[i][OP_W-2:FRAC_W]) && (|ops[i][FRAC_W-1:0]);
  end

  logic      anyNan;
  logic      bothZero;
  logic      magLess;
  fcmpCode_e code;
  logic [STAT_W-1:0] statNext;
  logic [3:0]        ccQ;
  logic [STAT_W-1:0] statQ;

  assign anyNan   = opNan[0] || opNan[1];
  assign bothZero = (opMag[0] == '0) && (opMag[1] == '0);
  assign magLess  = opMag[0] < opMag[1];

  always_comb begin
    if (anyNan)                      code = CC_UN;
    else if (bothZero)               code = CC_EQ;
    else if (opSign[0] != opSign[1]) code = opSign[0] ? CC_LT : CC_GT;
    else if (opMag[0] == opMag[1])   code = CC_EQ;
    else if (magLess ^ opSign[0])    code = CC_LT;
    else                             code = CC_GT;
  end

  always_comb begin
    statNext = statQ;
    statNext[CC_NIB*NIB_W +: NIB_W] = code;
    if (strobe.ordered) statNext[INV_BIT] = 1'b0;
    if (anyNan) begin
      statNext[INV_BIT] = 1'b1;
      if (strobe.ordered) statNext[INVX_BIT] = 1'b1;
      else                statNext[XNAN_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccQ   <= '0;
      statQ <= '0;
    end else if (strobe.load) begin
      ccQ   <= code;
      statQ <= statNext;
    end
  end

  assign ccOut  = ccQ;
  assign status = statQ;

  // R1
  nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && anyNan) |=> (ccQ == 4'b0001));
  // R2
  code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ccQ));
  // R6
  sticky_xnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(statQ[XNAN_BIT]));
  // R7
  ordered_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.ordered && !anyNan) |=> !statQ[INV_BIT]);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(ccQ) && $stable(statQ)));
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int STAT_NIBBLES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          ordMode,
  input  logic [EXP_W+FRAC_W:0]         opA,
  input  logic [EXP_W+FRAC_W:0]         opB,
  output logic [3:0]                    ccOut,
  output logic [STAT_NIBBLES*NIB_W-1:0] status,
  output logic                          done
);
  fcmpStrobe_t strobe;

  fcmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ordMode(ordMode),
    .strobe(strobe), .done(done)
  );

  fcmp_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .STAT_NIBBLES(STAT_NIBBLES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .ccOut(ccOut), .status(status)
  );
endmodule

// File: tb/fcmp_unit_test.sv
module fcmp_unit_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ordMode = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  ccOut;
  logic [31:0] status;
  logic        done;

  always #(CLK_P/2) clk = ~clk;

  fcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ordMode(ordMode),
    .opA(opA), .opB(opB), .ccOut(ccOut), .status(status), .done(done)
  );

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] MAXF = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] DENM = 64'h0000000000000001;

  int nChk = 0;
  int nFail = 0;
  logic [3:0]  eCc = '0;
  logic [31:0] eStat = '0;
  logic        eDone = 1'b0;
  string       eTag = "R9";
  string       eStatTag = "R9";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit isNan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic logic [3:0] refCode(logic [63:0] a, logic [63:0] b);
    real ra, rb;
    if (isNan(a) || isNan(b)) return 4'b0001;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'b1000;
    if (ra > rb) return 4'b0100;
    return 4'b0010;
  endfunction

  task automatic compareAll();
    chk(eTag, "ccOut", {28'd0, ccOut}, {28'd0, eCc});
    chk(eStatTag, "status", status, eStat);
    chk("R8", "done", {31'd0, done}, {31'd0, eDone});
  endtask

  task automatic step(bit s, bit m, logic [63:0] a, logic [63:0] b, string tag);
    logic [3:0] c;
    @(negedge clk);
    compareAll();
    start = s; ordMode = m; opA = a; opB = b;
    eDone = s;
    if (s) begin
      c = refCode(a, b);
      eCc = c;
      eStat[15:12] = c;
      if (m) eStat[16] = 1'b0;
      if (isNan(a) || isNan(b)) begin
        eStat[16] = 1'b1;
        if (m) eStat[19] = 1'b1;
        else   eStat[24] = 1'b1;
      end
      eTag = tag;
      eStatTag = m ? "R7 (R5)" : "R6 (R5)";
    end else begin
      eTag = "R8";
      eStatTag = "R8";
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    compareAll();
    rst_n = 1'b0; start = 1'b0;
    eCc = '0; eStat = '0; eDone = 1'b0; eTag = "R9"; eStatTag = "R9";
    @(negedge clk);
    compareAll();
    rst_n = 1'b1;
  endtask

  bit finished = 1'b0;

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compareAll();           // R9 reset state
    rst_n = 1'b1;
    // R2 ordinary ordering
    step(1, 0, P1, P2, "R2");
    step(1, 0, P2, P1, "R2");
    step(1, 0, P2, P2, "R2");
    step(1, 0, N1, N2, "R2");
    step(1, 0, N2, N1, "R2");
    step(1, 0, N1, P1, "R2");
    step(1, 0, P1, N2, "R2");
    step(1, 1, DENM, PZ, "R2");
    step(0, 0, PZ, PZ, "R8");
    step(0, 1, QNAN, QNAN, "R8");
    // R3 signed zeros
    step(1, 0, PZ, NZ, "R3");
    step(1, 1, NZ, PZ, "R3");
    step(1, 0, NZ, DENM, "R3");
    // R4 infinities
    step(1, 0, NINF, N2, "R4");
    step(1, 0, PINF, MAXF, "R4");
    step(1, 0, PINF, PINF, "R4");
    step(1, 1, NINF, NINF, "R4");
    step(1, 0, NINF, PINF, "R4");
    step(1, 1, MAXF, PINF, "R4");
    // R1 and R6 unordered NaN, sticky
    step(1, 0, QNAN, P1, "R1");
    step(0, 0, P1, P1, "R8");
    step(1, 0, P1, P2, "R6");
    step(1, 0, P1, SNAN, "R1");
    // R7 ordered clears bit 16, keeps bit 24
    step(1, 1, P2, P1, "R7");
    step(1, 1, SNAN, QNAN, "R1");
    step(1, 1, NZ, PZ, "R7");
    step(1, 0, PINF, QNAN, "R1");
    step(1, 1, N1, N1, "R7");
    step(0, 0, P1, P2, "R8");
    step(0, 0, P1, P2, "R8");
    // R9 reset mid-run
    doReset();
    step(1, 1, QNAN, PINF, "R1");
    step(1, 0, P1, NZ, "R2");
    step(0, 0, PZ, PZ, "R8");
    @(negedge clk);
    compareAll();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule